// File: doc/BRIEF.md
# Carry-Select Add/Subtract Unit

This block is a purely combinational 8-bit adder/subtractor intended to sit between two register stages in an iterative divider datapath, where each step either adds or subtracts the divisor from a partial remainder. One control input picks the operation. When subtracting, the second operand is bitwise inverted and the same control is fed in as the low carry, so that a single adder forms the two's-complement difference.

The operand is split into two 4-bit halves. A ripple slice handles the low half. The high half is computed twice at the same time: one copy assumes a carry of 0 into bit 4 and the other assumes a carry of 1. The real carry out of the low slice then drives a final selector. That selector picks the high sum bits and the final carry-out, so the high half never waits for the low ripple to finish.

Top module: `csa_addsub`

## Requirements
- R1: With `op_sub` = 0 (add), `{carry_out, result}` equals the 9-bit sum `op_a + op_b`.
- R2: With `op_sub` = 1 (subtract), `result` equals `(op_a - op_b) mod 256`. `carry_out` is 1 exactly when `op_a >= op_b`, that is, when no borrow occurs.
- R3: Subtracting equal operands gives `result` = 0 with `carry_out` = 1. For example, 5 minus 5 gives 0 with carry 1.
- R4: `result[3:0]` equals `(op_a[3:0] + (op_b[3:0] XOR {4{op_sub}}) + op_sub) mod 16`. It depends only on the low nibbles and the mode.
- R5: With `op_b` = 0, `result` equals `op_a`. `carry_out` then equals `op_sub`.
- R6: The wrap boundaries behave as follows: 255 + 1 gives 0 with carry 1, and 0 - 1 gives 255 with carry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand (minuend or addend) |
| op_b | input | 8 | Second operand (subtrahend or addend) |
| op_sub | input | 1 | Operation select: 0 = add, 1 = subtract |
| result | output | 8 | Sum or difference, modulo 256 |
| carry_out | output | 1 | Carry out of bit 7; when subtracting, 1 means no borrow |

## Verification
The assertions are immediate checks on the settled port values, and they assume every operand and mode bit is a known 0 or 1. Each check is skipped while any input is unknown. The stimulus changes inputs only on the falling clock edge and reads the outputs one nanosecond later, once the combinational logic has settled. It drives only 2-state values and walks every operand pair in both modes, so each assertion sees the complete legal input space.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Full operand width and the width of one ripple slice.
    localparam int unsigned CSA_WIDTH   = 8;
    localparam int unsigned CSA_SLICE_W = CSA_WIDTH / 2;

    typedef logic [CSA_WIDTH-1:0]   word_t;
    typedef logic [CSA_SLICE_W-1:0] nib_t;

    // Operation select encoding.
    typedef enum logic {
        CSA_OP_ADD = 1'b0,
        CSA_OP_SUB = 1'b1
    } csa_op_e;

    // Output of one slice: nibble sum plus its carry.
    typedef struct packed {
        logic cout;
        nib_t sum;
    } slice_res_t;

    // Conditioning of the second operand: invert every bit when subtracting.
    function automatic nib_t cond_invert(input nib_t v, input csa_op_e op);
        return v ^ {CSA_SLICE_W{op == CSA_OP_SUB}};
    endfunction

endpackage

// File: rtl/csa_operand_cond.sv
module csa_operand_cond
    import csa_pkg::*;
(
    input  word_t   b_in,
    input  csa_op_e op,
    output nib_t    b_lo,
    output nib_t    b_hi
);
    // Each half passes through its own row of XOR gates.
    assign b_lo = cond_invert(b_in[CSA_SLICE_W-1:0], op);
    assign b_hi = cond_invert(b_in[CSA_WIDTH-1:CSA_SLICE_W], op);
endmodule

// File: rtl/csa_ripple_slice.sv
module csa_ripple_slice
    import csa_pkg::*;
(
    input  nib_t       x,
    input  nib_t       y,
    input  logic       cin,
    output slice_res_t res
);
    logic [CSA_SLICE_W:0] chain;
    nib_t                 s;

    assign chain[0] = cin;

    // One full-adder cell per bit, with the carry rippling upward.
    for (genvar i = 0; i < CSA_SLICE_W; i++) begin : g_fa
        logic p;
        assign p          = x[i] ^ y[i];
        assign s[i]       = p ^ chain[i];
        assign chain[i+1] = (x[i] & y[i]) | (p & chain[i]);
    end

    assign res.sum  = s;
    assign res.cout = chain[CSA_SLICE_W];
endmodule

// File: rtl/csa_result_mux.sv
module csa_result_mux
    import csa_pkg::*;
(
    input  logic       pick_one,
    input  slice_res_t cand_c0,
    input  slice_res_t cand_c1,
    output slice_res_t chosen
);
    always_comb begin
        if (pick_one) chosen = cand_c1;
        else          chosen = cand_c0;
    end
endmodule

// File: rtl/csa_addsub.sv
module csa_addsub
    import csa_pkg::*;
(
    input  logic [7:0] op_a,
    input  logic [7:0] op_b,
    input  logic       op_sub,
    output logic [7:0] result,
    output logic       carry_out
);
    localparam int unsigned NUM_CAND = 2;

    csa_op_e    op;
    nib_t       b_lo_c;
    nib_t       b_hi_c;
    slice_res_t lo_res;
    slice_res_t hi_res;
    slice_res_t hi_cand [NUM_CAND];

    assign op = csa_op_e'(op_sub);

    csa_operand_cond u_cond (
        .b_in (op_b),
        .op   (op),
        .b_lo (b_lo_c),
        .b_hi (b_hi_c)
    );

    // Low slice: a carry-in equal to the subtract flag completes the negation.
    csa_ripple_slice u_lo (
        .x   (op_a[CSA_SLICE_W-1:0]),
        .y   (b_lo_c),
        .cin (op == CSA_OP_SUB),
        .res (lo_res)
    );

    // High half: one speculative slice per possible carry into bit 4.
    for (genvar k = 0; k < NUM_CAND; k++) begin : g_hi
        csa_ripple_slice u_hi (
            .x   (op_a[CSA_WIDTH-1:CSA_SLICE_W]),
            .y   (b_hi_c),
            .cin (k[0]),
            .res (hi_cand[k])
        );
    end

    csa_result_mux u_sel (
        .pick_one (lo_res.cout),
        .cand_c0  (hi_cand[0]),
        .cand_c1  (hi_cand[1]),
        .chosen   (hi_res)
    );

    assign result    = {hi_res.sum, lo_res.sum};
    assign carry_out = hi_res.cout;
endmodule

// File: rtl/csa_addsub_chk.sv
module csa_addsub_chk (
    input logic [7:0] op_a,
    input logic [7:0] op_b,
    input logic       op_sub,
    input logic [7:0] result,
    input logic       carry_out
);
    logic known;
    logic [8:0] wide_add;
    logic [3:0] low_exp;

    assign known    = !$isunknown({op_a, op_b, op_sub});
    assign wide_add = {1'b0, op_a} + {1'b0, op_b};
    assign low_exp  = op_a[3:0] + (op_b[3:0] ^ {4{op_sub}}) + {3'b000, op_sub};

    always_comb begin
        if (known) begin
            if (!op_sub) begin
                AST_ADD_RESULT: assert ({carry_out, result} == wide_add); // R1
            end
            if (op_sub) begin
                AST_SUB_RESULT: assert (result == 8'(op_a - op_b) && carry_out == (op_a >= op_b)); // R2
            end
            if (op_sub && op_a == op_b) begin
                AST_EQUAL_ZERO: assert (result == 8'd0 && carry_out); // R3
            end
            AST_LOW_NIBBLE: assert (result[3:0] == low_exp); // R4
            if (op_b == 8'd0) begin
                AST_ZERO_OPERAND: assert (result == op_a && carry_out == op_sub); // R5
            end
            if (op_a == 8'd0 && op_b == 8'd1 && op_sub) begin
                AST_WRAP_BORROW: assert (result == 8'hFF && !carry_out); // R6
            end
        end
    end
endmodule

bind csa_addsub csa_addsub_chk u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sub    (op_sub),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/csa_addsub_bench.sv
module csa_addsub_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_a = 8'd0;
    logic [7:0] op_b = 8'd0;
    logic       op_sub = 1'b0;
    logic [7:0] result;
    logic       carry_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    csa_addsub u_csa_addsub (
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sub    (op_sub),
        .result    (result),
        .carry_out (carry_out)
    );

    task automatic cmp(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s a=%0d b=%0d sub=%0d actual=%0d expected=%0d",
                     tag, op_a, op_b, op_sub, got, exp);
        end
    endtask

    // Behavioural reference from the requirements, using plain integers.
    task automatic apply(input int a, input int b, input int s, input string tag);
        int ref_val;
        int ref_c;
        @(negedge clk);
        op_a   = 8'(a);
        op_b   = 8'(b);
        op_sub = s[0];
        #1;
        if (s == 0) begin
            ref_val = (a + b) % 256;
            ref_c   = (a + b) / 256;
        end else begin
            ref_val = (a - b + 256) % 256;
            ref_c   = (a >= b) ? 1 : 0;
        end
        cmp({tag, " result"}, int'(result), ref_val);
        cmp({tag, " carry"}, int'(carry_out), ref_c);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: zero operands, add mode (R1).
        @(negedge clk); #1;
        cmp("R1 idle result", int'(result), 0);
        cmp("R1 idle carry", int'(carry_out), 0);

        // Directed corners.
        apply(5, 5, 1, "R3 five minus five");
        apply(200, 200, 1, "R3 equal operands");
        apply(255, 1, 0, "R6 add wrap");
        apply(0, 1, 1, "R6 sub wrap");
        apply(173, 0, 0, "R5 add zero");
        apply(173, 0, 1, "R5 sub zero");
        apply(15, 1, 0, "R4 low carry into high half");
        apply(16, 1, 1, "R4 low borrow from high half");

        // Exhaustive sweep of both modes (R1 add, R2 subtract, R4 low nibble).
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    apply(a, b, s, (s == 0) ? "R1 sweep" : "R2 sweep");
                    cmp("R4 low nibble", int'(result[3:0]),
                        (a % 16 + ((s == 0) ? b % 16 : 15 - b % 16) + s) % 16);
                end
            end
        end
        done = 1;
        finish_run();
    end
endmodule